// File: doc/BRIEF.md
# OTP Page Program Sequencer

This block is a host-side controller that burns one page of a flash device's one-time-programmable area. It reaches the device only through a 16-bit synchronous register bus. A single request pulse is enough to start it. The block then writes the die and block setup words, copies a page of host data into the device's buffer RAM, enters OTP access mode, and sets the page and buffer-start words. After that it issues the program command and polls the interrupt word until the device signals completion. Once the device is done, the block reads the controller status and asks the system for a device reset, which takes the device out of OTP mode.

The host supplies page data one word at a time. The sequencer presents a word index, and the host returns the matching data word in the same cycle. Several inputs are captured when a run is accepted:

- the die select,
- the auto-interrupt mode flag,
- the page number,
- a poll limit.

If the device never completes, the poll limit turns the hang into a timeout result. Each run ends with a one-cycle done pulse. The pass, error, lock and timeout flags stay valid after that pulse until the next accepted start.

Top module: `otp_prog_seq`

## Requirements
- R1: A start pulse while idle begins a run. busy is high from the next cycle until the cycle of a one-cycle done pulse, and busy is low during that done cycle. A start pulse while busy is ignored. When idle, no bus strobe and no reset request is driven.
- R2: At most one of bus_wr and bus_rd is high at a time. A transfer completes in a cycle where its strobe and bus_ready are both high. Until then, the strobe, address and write data are held unchanged.
- R3: With DUAL_DIE set, the first write goes to 0xF101 and carries die_sel in bit 15 with all other bits zero. The next write goes to 0xF100 with the same value, so the block-address field in bits 14:0 is always zero.
- R4: The page data comes next as WORDS writes to addresses BUF_BASE+i, for i = 0 upward. Each write carries the dat_in value presented while dat_idx equals i. All of these writes come before the program command.
- R5: After the page data, 0x0065 is written to 0xF220, and 0xF241 is then polled.
- R6: After that wait, the block writes 0xF107 with page_addr in bits PAGE_W+1:2 and zero in bits 1:0. It then writes 0x0800 to 0xF200, and then writes 0x0080 to 0xF220.
- R7: Each wait reads 0xF241 repeatedly and ends on the first read whose bit 15 is 1.
- R8: When auto_int is low at start, every completed wait is followed by a write of 0x0000 to 0xF241. When auto_int is high, the block never writes 0xF241.
- R9: After the program wait, 0xF240 is read. err takes bit 10, lock takes bit 14, and pass is the inverse of bit 10.
- R10: In any single wait, once the number of reads with bit 15 clear reaches tmo_lim (taken as 1 when tmo_lim is 0), the run aborts. tmo is set, pass is 0, and no further bus write is issued.
- R11: Every run, including an aborted one, ends by holding rst_req high until rst_ack. done follows in the cycle after the cycle where rst_req and rst_ack are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request pulse |
| die_sel | input | 1 | Die choice for dual-die parts |
| auto_int | input | 1 | Device clears its interrupt by itself; skip clear writes |
| page_addr | input | PAGE_W | OTP page number |
| tmo_lim | input | TMO_W | Failing poll reads allowed per wait |
| dat_idx | output | IDX_W | Index of the page word wanted |
| dat_in | input | 16 | Page word for dat_idx |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 16 | Write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 16 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Transfer completes this cycle |
| rst_req | output | 1 | Device reset request |
| rst_ack | input | 1 | Device reset done |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Program passed |
| err | output | 1 | Device reported an error |
| lock | output | 1 | OTP area was locked |
| tmo | output | 1 | Poll limit reached |

## Verification
The assertions assume that auto_int is held steady while a run is active, because the checker compares it directly against writes to the interrupt word. They also assume that bus_ready and rst_ack are only ever answers to the block's own strobe or request. The bench's device model respects both: it changes auto_int only between runs, and it raises bus_ready and rst_ack only while a strobe or request is pending. Random wait states and random completion delays vary the timing. Tight poll limits and a device that never completes push the timeout path.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_BUFSEL, S_BLK, S_DATA, S_ACC, S_POLL_A, S_CLR_A,
      S_PAGE, S_BSTART, S_PROG, S_POLL_P, S_STAT, S_CLR_P, S_RST, S_FIN
   } seq_st_t;

   localparam logic [15:0] A_BUFSEL = 16'hF101;
   localparam logic [15:0] A_BLK    = 16'hF100;
   localparam logic [15:0] A_PAGE   = 16'hF107;
   localparam logic [15:0] A_BSTART = 16'hF200;
   localparam logic [15:0] A_CMD    = 16'hF220;
   localparam logic [15:0] A_STAT   = 16'hF240;
   localparam logic [15:0] A_INT    = 16'hF241;

   localparam logic [15:0] CMD_OTP    = 16'h0065;
   localparam logic [15:0] CMD_PROG   = 16'h0080;
   localparam logic [15:0] BSTART_VAL = 16'h0800;

   localparam int INT_BIT  = 15;
   localparam int LOCK_BIT = 14;
   localparam int ERR_BIT  = 10;

endpackage

// File: rtl/otp_poll_timer.sv
module otp_poll_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             miss,
   input  logic [TMO_W-1:0] lim,
   output logic             expired
);
   logic [TMO_W-1:0] cnt;
   logic [TMO_W:0]   cnt_nx;

   assign cnt_nx  = {1'b0, cnt} + {{TMO_W{1'b0}}, 1'b1};
   assign expired = miss && (cnt_nx >= {1'b0, lim});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (miss)  cnt <= cnt_nx[TMO_W-1:0];
   end
endmodule

// File: rtl/otp_word_ctr.sv
module otp_word_ctr #(
   parameter int WORDS = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [IDX_W-1:0] idx,
   output logic             last
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

   assign last = (idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx <= '0;
      else if (clr)   idx <= '0;
      else if (adv)   idx <= last ? '0 : idx + 1'b1;
   end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
   import otp_seq_pkg::*;
#(
   parameter int          WORDS    = 16,
   parameter int          PAGE_W   = 6,
   parameter int          TMO_W    = 16,
   parameter int          DUAL_DIE = 1,
   parameter logic [15:0] BUF_BASE = 16'h0200,
   localparam int         IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              die_sel,
   input  logic              auto_int,
   input  logic [PAGE_W-1:0] page_addr,
   input  logic [TMO_W-1:0]  tmo_lim,
   output logic [IDX_W-1:0]  dat_idx,
   input  logic [15:0]       dat_in,
   output logic [15:0]       bus_addr,
   output logic [15:0]       bus_wdata,
   output logic              bus_wr,
   output logic              bus_rd,
   input  logic [15:0]       bus_rdata,
   input  logic              bus_ready,
   output logic              rst_req,
   input  logic              rst_ack,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              err,
   output logic              lock,
   output logic              tmo
);

   if (WORDS < 1)                 begin : g_bad_words  $error("WORDS must be at least 1");     end
   if (PAGE_W < 1 || PAGE_W > 14) begin : g_bad_page   $error("PAGE_W must be 1 to 14");       end
   if (TMO_W < 1)                 begin : g_bad_tmo    $error("TMO_W must be at least 1");     end
   if (32'(BUF_BASE) + WORDS > 32'h0000_F000) begin : g_bad_base
      $error("buffer window overlaps the register area");
   end

   seq_st_t            st, st_nx;
   logic               die_bit, use_bufsel;
   logic               die_q, auto_q;
   logic [PAGE_W-1:0]  page_q;
   logic [TMO_W-1:0]   lim_q;
   logic               pass_q, err_q, lock_q, tmo_q;
   logic               is_poll, miss, expired, abort;
   logic               last_word;
   logic [IDX_W-1:0]   idx;
   logic               unused_rd;

   assign unused_rd = ^{bus_rdata[13:11], bus_rdata[9:0]};

   if (DUAL_DIE != 0) begin : g_dual
      assign die_bit    = die_sel;
      assign use_bufsel = 1'b1;
   end else begin : g_single
      logic unused_die;
      assign unused_die = die_sel;
      assign die_bit    = 1'b0;
      assign use_bufsel = 1'b0;
   end

   assign is_poll = (st == S_POLL_A) || (st == S_POLL_P);
   assign miss    = is_poll && bus_ready && !bus_rdata[INT_BIT];
   assign abort   = miss && expired;

   otp_poll_timer #(.TMO_W(TMO_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(!is_poll), .miss(miss),
      .lim(lim_q), .expired(expired)
   );

   otp_word_ctr #(.WORDS(WORDS), .IDX_W(IDX_W)) u_words (
      .clk(clk), .rst_n(rst_n), .clr(st != S_DATA),
      .adv((st == S_DATA) && bus_ready), .idx(idx), .last(last_word)
   );

   assign dat_idx = idx;

   always_comb begin
      st_nx = st;
      unique case (st)
         S_IDLE:   if (start) st_nx = use_bufsel ? S_BUFSEL : S_BLK;
         S_BUFSEL: if (bus_ready) st_nx = S_BLK;
         S_BLK:    if (bus_ready) st_nx = S_DATA;
         S_DATA:   if (bus_ready && last_word) st_nx = S_ACC;
         S_ACC:    if (bus_ready) st_nx = S_POLL_A;
         S_POLL_A: if (bus_ready) begin
                      if (bus_rdata[INT_BIT]) st_nx = auto_q ? S_PAGE : S_CLR_A;
                      else if (abort)         st_nx = S_RST;
                   end
         S_CLR_A:  if (bus_ready) st_nx = S_PAGE;
         S_PAGE:   if (bus_ready) st_nx = S_BSTART;
         S_BSTART: if (bus_ready) st_nx = S_PROG;
         S_PROG:   if (bus_ready) st_nx = S_POLL_P;
         S_POLL_P: if (bus_ready) begin
                      if (bus_rdata[INT_BIT]) st_nx = S_STAT;
                      else if (abort)         st_nx = S_RST;
                   end
         S_STAT:   if (bus_ready) st_nx = auto_q ? S_RST : S_CLR_P;
         S_CLR_P:  if (bus_ready) st_nx = S_RST;
         S_RST:    if (rst_ack) st_nx = S_FIN;
         S_FIN:    st_nx = S_IDLE;
         default:  st_nx = S_IDLE;
      endcase
   end

   always_comb begin
      bus_addr  = '0;
      bus_wdata = '0;
      bus_wr    = 1'b0;
      bus_rd    = 1'b0;
      unique case (st)
         S_BUFSEL: begin bus_wr = 1'b1; bus_addr = A_BUFSEL; bus_wdata = {die_q, 15'b0}; end
         S_BLK:    begin bus_wr = 1'b1; bus_addr = A_BLK;    bus_wdata = {die_q, 15'b0}; end
         S_DATA:   begin bus_wr = 1'b1; bus_addr = BUF_BASE + 16'(idx); bus_wdata = dat_in; end
         S_ACC:    begin bus_wr = 1'b1; bus_addr = A_CMD;    bus_wdata = CMD_OTP; end
         S_POLL_A,
         S_POLL_P: begin bus_rd = 1'b1; bus_addr = A_INT; end
         S_CLR_A,
         S_CLR_P:  begin bus_wr = 1'b1; bus_addr = A_INT;    bus_wdata = '0; end
         S_PAGE:   begin bus_wr = 1'b1; bus_addr = A_PAGE;   bus_wdata = 16'(page_q) << 2; end
         S_BSTART: begin bus_wr = 1'b1; bus_addr = A_BSTART; bus_wdata = BSTART_VAL; end
         S_PROG:   begin bus_wr = 1'b1; bus_addr = A_CMD;    bus_wdata = CMD_PROG; end
         S_STAT:   begin bus_rd = 1'b1; bus_addr = A_STAT; end
         default:  ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         die_q  <= 1'b0;
         auto_q <= 1'b0;
         page_q <= '0;
         lim_q  <= '0;
         pass_q <= 1'b0;
         err_q  <= 1'b0;
         lock_q <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         st <= st_nx;
         if (st == S_IDLE && start) begin
            die_q  <= die_bit;
            auto_q <= auto_int;
            page_q <= page_addr;
            lim_q  <= tmo_lim;
            pass_q <= 1'b0;
            err_q  <= 1'b0;
            lock_q <= 1'b0;
            tmo_q  <= 1'b0;
         end
         if (st == S_STAT && bus_ready) begin
            err_q  <= bus_rdata[ERR_BIT];
            lock_q <= bus_rdata[LOCK_BIT];
            pass_q <= !bus_rdata[ERR_BIT];
         end
         if (abort) tmo_q <= 1'b1;
      end
   end

   assign rst_req = (st == S_RST);
   assign busy    = (st != S_IDLE) && (st != S_FIN);
   assign done    = (st == S_FIN);
   assign pass    = pass_q;
   assign err     = err_q;
   assign lock    = lock_q;
   assign tmo     = tmo_q;

endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk
   import otp_seq_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        auto_int,
   input logic [15:0] bus_addr,
   input logic [15:0] bus_wdata,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic        bus_ready,
   input logic        rst_req,
   input logic        rst_ack,
   input logic        busy,
   input logic        done,
   input logic        pass,
   input logic        err,
   input logic        tmo
);

   p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   p_hold_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !bus_ready |=> bus_wr && $stable(bus_addr) && $stable(bus_wdata));

   p_hold_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && !bus_ready |=> bus_rd && $stable(bus_addr));

   p_blk_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_BLK |-> bus_wdata[14:0] == 15'd0);

   p_sector_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_PAGE |-> bus_wdata[1:0] == 2'b00);

   p_bstart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_BSTART |-> bus_wdata == BSTART_VAL);

   p_auto_noclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_INT |-> !auto_int);

   p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_wr && !bus_rd && !rst_req);

   p_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done && pass |-> !err);

   p_tmo_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done && tmo |-> !pass);

   p_reset_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rst_req && rst_ack));

endmodule

bind otp_prog_seq otp_prog_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .auto_int(auto_int),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_ready(bus_ready), .rst_req(rst_req), .rst_ack(rst_ack),
   .busy(busy), .done(done), .pass(pass), .err(err), .tmo(tmo)
);

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb;
   localparam int          WORDS    = 16;
   localparam int          PAGE_W   = 6;
   localparam int          TMO_W    = 16;
   localparam int          IDX_W    = 4;
   localparam logic [15:0] BUF_BASE = 16'h0200;

   logic clk, rst_n, start, die_sel, auto_int;
   logic [PAGE_W-1:0] page_addr;
   logic [TMO_W-1:0]  tmo_lim;
   logic [IDX_W-1:0]  dat_idx;
   logic [15:0]       dat_in, bus_addr, bus_wdata, bus_rdata;
   logic bus_wr, bus_rd, bus_ready, rst_req, rst_ack;
   logic busy, done, pass, err, lock, tmo;

   int checks = 0;
   int errors = 0;

   initial clk = 1'b0;
   always #10 clk = ~clk;

   otp_prog_seq #(.WORDS(WORDS), .PAGE_W(PAGE_W), .TMO_W(TMO_W), .DUAL_DIE(1),
                  .BUF_BASE(BUF_BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .die_sel(die_sel), .auto_int(auto_int),
      .page_addr(page_addr), .tmo_lim(tmo_lim), .dat_idx(dat_idx), .dat_in(dat_in),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .rst_req(rst_req), .rst_ack(rst_ack),
      .busy(busy), .done(done), .pass(pass), .err(err), .lock(lock), .tmo(tmo)
   );

   // device model
   int          wcnt, int_cnt, p2_reads;
   logic        int_flag, arm, ph2, rst_seen, hang, m_err, m_lock;
   logic [15:0] stat;
   logic [7:0]  tag;
   logic [31:0] wlog[$];

   function automatic logic [15:0] pat(input logic [7:0] t, input int i);
      return {t, 4'h0, 4'(i)} ^ 16'h5A3C;
   endfunction

   assign dat_in    = pat(tag, int'(dat_idx));
   assign bus_ready = (bus_wr || bus_rd) && (wcnt == 0);
   assign bus_rdata = (bus_addr == 16'hF241) ? {int_flag, 15'b0} :
                      (bus_addr == 16'hF240) ? stat : 16'h0000;

   always @(posedge clk) begin
      if (!rst_n) begin
         wcnt <= 0; int_cnt <= 0; p2_reads <= 0; int_flag <= 1'b0; arm <= 1'b0;
         ph2 <= 1'b0; rst_seen <= 1'b0; rst_ack <= 1'b0; stat <= 16'h0;
      end else begin
         if (start && !busy) begin
            wlog.delete(); p2_reads <= 0; rst_seen <= 1'b0;
         end
         if (arm) begin
            if (int_cnt == 0) begin int_flag <= 1'b1; arm <= 1'b0; end
            else int_cnt <= int_cnt - 1;
         end
         if (bus_ready) begin
            wcnt <= int'($urandom % 3);
            if (bus_wr) begin
               wlog.push_back({bus_addr, bus_wdata});
               if (bus_addr == 16'hF220 && bus_wdata == 16'h0065) int_flag <= 1'b1;
               if (bus_addr == 16'hF220 && bus_wdata == 16'h0080) begin
                  ph2  <= 1'b1;
                  stat <= {1'b0, m_lock, 3'b000, m_err | m_lock, 10'b0};
                  if (!hang) begin arm <= 1'b1; int_cnt <= int'($urandom % 6); end
               end
               if (bus_addr == 16'hF241) int_flag <= bus_wdata[15];
            end else if (bus_addr == 16'hF241) begin
               if (ph2) p2_reads <= p2_reads + 1;
               if (auto_int && int_flag) int_flag <= 1'b0;
            end
         end else if (bus_wr || bus_rd) begin
            wcnt <= wcnt - 1;
         end
         if (rst_req) begin
            rst_seen <= 1'b1;
            rst_ack  <= !rst_ack && ($urandom % 2 == 0);
         end else begin
            rst_ack <= 1'b0;
         end
         if (rst_req && rst_ack) begin
            int_flag <= 1'b0; stat <= 16'h0; ph2 <= 1'b0; arm <= 1'b0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic die, input logic au, input logic [PAGE_W-1:0] pg,
                         input logic e, input logic l, input logic h, input int lim,
                         input logic restart);
      logic [31:0] exp[$];
      int n;
      int mism;
      logic pass_e, err_e, lock_e;
      @(negedge clk);
      die_sel = die; auto_int = au; page_addr = pg; m_err = e; m_lock = l; hang = h;
      tmo_lim = TMO_W'(lim); tag = 8'($urandom); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R1 busy after start", 32'(busy), 32'd1);
      if (restart) begin
         repeat (10) @(negedge clk);
         start = 1'b1; page_addr = ~pg; die_sel = ~die;
         @(negedge clk);
         start = 1'b0; page_addr = pg; die_sel = die;
      end
      n = 0;
      while (done !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
      chk(done === 1'b1, "R1 done reached", 32'(n), 32'd5000);
      chk(busy === 1'b0, "R1 busy low with done", 32'(busy), 32'd0);
      chk(rst_seen === 1'b1, "R11 reset requested before done", 32'(rst_seen), 32'd1);

      exp.push_back({16'hF101, die, 15'b0});
      exp.push_back({16'hF100, die, 15'b0});
      for (int i = 0; i < WORDS; i++) exp.push_back({BUF_BASE + 16'(i), pat(tag, i)});
      exp.push_back({16'hF220, 16'h0065});
      if (!au) exp.push_back({16'hF241, 16'h0000});
      exp.push_back({16'hF107, 16'(pg) << 2});
      exp.push_back({16'hF200, 16'h0800});
      exp.push_back({16'hF220, 16'h0080});
      if (!h && !au) exp.push_back({16'hF241, 16'h0000});

      chk(wlog.size() == exp.size(), "R3 R4 R5 R6 R8 R10 write count",
          32'(wlog.size()), 32'(exp.size()));
      mism = -1;
      for (int i = 0; i < exp.size() && i < wlog.size(); i++)
         if (mism < 0 && wlog[i] !== exp[i]) mism = i;
      chk(mism < 0, "R3 R4 R5 R6 R8 write order and values",
          (mism < 0) ? 32'd0 : wlog[mism], (mism < 0) ? 32'd0 : exp[mism]);

      pass_e = !(e || l) && !h;
      err_e  = h ? 1'b0 : (e || l);
      lock_e = h ? 1'b0 : l;
      chk({pass, err, lock, tmo} === {pass_e, err_e, lock_e, h},
          h ? "R10 timeout verdict" : "R9 status verdict",
          32'({pass, err, lock, tmo}), 32'({pass_e, err_e, lock_e, h}));
      if (h)
         chk(p2_reads == ((lim < 1) ? 1 : lim), "R10 poll reads before abort",
             32'(p2_reads), 32'((lim < 1) ? 1 : lim));
      else
         chk(p2_reads >= 1, "R7 program wait polled", 32'(p2_reads), 32'd1);
      @(negedge clk);
      chk(done === 1'b0, "R1 done is one cycle", 32'(done), 32'd0);
      if (restart) begin
         repeat (3) @(negedge clk);
         chk(busy === 1'b0 && !bus_wr && !bus_rd, "R1 start while busy ignored",
             32'(busy), 32'd0);
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; start = 1'b0; die_sel = 1'b0; auto_int = 1'b0; page_addr = '0;
      tmo_lim = '0; hang = 1'b0; m_err = 1'b0; m_lock = 1'b0; tag = 8'h00;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !bus_wr && !bus_rd, "R1 idle in reset",
          32'({busy, done, bus_wr, bus_rd}), 32'd0);
      chk(rst_req === 1'b0, "R11 no reset request in reset", 32'(rst_req), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({pass, err, lock, tmo} === 4'b0000, "R9 flags clear after reset",
          32'({pass, err, lock, tmo}), 32'd0);

      run_op(1'b0, 1'b0, 6'h05, 1'b0, 1'b0, 1'b0, 200, 1'b0);
      run_op(1'b1, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b0, 200, 1'b0);
      run_op(1'b0, 1'b0, 6'h00, 1'b1, 1'b0, 1'b0, 200, 1'b0);
      run_op(1'b1, 1'b0, 6'h2A, 1'b0, 1'b1, 1'b0, 200, 1'b0);
      run_op(1'b0, 1'b0, 6'h11, 1'b0, 1'b0, 1'b1, 3, 1'b0);
      run_op(1'b1, 1'b1, 6'h07, 1'b0, 1'b0, 1'b1, 0, 1'b0);
      run_op(1'b0, 1'b1, 6'h09, 1'b0, 1'b0, 1'b0, 200, 1'b1);
      for (int k = 0; k < 12; k++) begin
         logic rh;
         rh = ($urandom % 4 == 0);
         run_op(1'($urandom), 1'($urandom), 6'($urandom), 1'($urandom), 1'($urandom),
                rh, rh ? int'($urandom % 6) : 200, 1'b0);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule